// File: doc/BRIEF.md
# Serial Accumulating Adder

This block adds two unsigned operands one bit per clock. Two right-shifting registers hold the augend and the addend, and the two bits at their low ends go into a one-bit full adder together with a stored carry. Each new sum bit enters the augend register at its top end, in the position the shift has just freed. After `WIDTH` shift cycles the augend register holds the sum and the carry flip-flop holds the carry-out. No third register is used for the result.

The block can also keep a running total. After an addition, the caller loads only a new addend and strobes start again. The previous sum stays in place as the augend, and the carry left by the previous addition acts as the carry-in. Loading a fresh augend begins a new sequence and clears the carry. While a shift sequence runs, the block ignores load and start requests. When the sequence ends it raises `done` for one cycle and then holds its state.

Top module: `serial_accum_adder`

## Requirements
- R1: After a synchronous reset, `sum` is 0, `carry_out` is 0 and `done` is 0.
- R2: While no addition is running, `ld_aug` copies `aug_in` into the augend register, which `sum` shows after the next edge, and clears `carry_out`. `ld_add` copies `add_in` into the addend register and leaves `carry_out` unchanged.
- R3: When `start` is sampled high at edge k while idle, `done` is high for exactly the one cycle after edge k+WIDTH and low in every other cycle around it.
- R4: When `done` is high, {`carry_out`,`sum`} equals A + B + C. A is the augend at start, B is the addend at start and C is the carry present at start.
- R5: The operands 4'b1011 and 4'b1001 with a cleared carry give `sum` 4'b0100 and `carry_out` 1.
- R6: Loading only a new addend and starting again adds it to the sum left by the previous addition, with the previous carry as carry-in. This works over chains of any length.
- R7: The addend register is zero after every addition. A start with no new addend load therefore produces A + 0 + C.
- R8: `ld_aug`, `ld_add` and `start` asserted while an addition is running have no effect on the result or on the timing of `done`.
- R9: When idle and given no requests, `sum` and `carry_out` hold their values and `done` stays low.
- R10: A `start` in the same cycle as `ld_aug` or `ld_add` is ignored. The load still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_aug | input | 1 | Load the augend register from `aug_in` and clear the carry |
| aug_in | input | WIDTH | Augend value |
| ld_add | input | 1 | Load the addend register from `add_in` |
| add_in | input | WIDTH | Addend value |
| start | input | 1 | Begin a serial addition |
| done | output | 1 | One-cycle pulse when an addition completes |
| sum | output | WIDTH | Augend register contents; the sum once `done` rises |
| carry_out | output | 1 | Carry flip-flop |

## Verification
The hardest case to reach from the ports is the addend register being zero after an addition, because that register never appears on an output. The bench exposes it by starting a second addition without a new addend load and checking that only the carry gets added. A related case is a carry that stays set across an addend-only reload. The random accumulation chains reach it by using operands large enough to overflow often. Requests that arrive while a run is in progress are injected on the edges inside the run, and the bench then checks both the result and the exact cycle in which `done` rises.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    // returns {carry, sum} of a one-bit full addition
    function automatic logic [1:0] full_add(input logic x, input logic y, input logic cin);
        logic s;
        logic c;
        s = x ^ y ^ cin;
        c = (x & y) | (x & cin) | (y & cin);
        return {c, s};
    endfunction

endpackage

// File: rtl/sacc_ctrl.sv
module sacc_ctrl #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ld_aug,
    input  logic ld_add,
    input  logic start,
    output logic shift_en,
    output logic ld_aug_en,
    output logic ld_add_en,
    output logic done
);
    import sacc_pkg::*;

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        phase_e          phase;
        logic [CW-1:0]   cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  running;
    logic  go;

    assign running   = (st_q.phase == PH_RUN);
    assign ld_aug_en = ld_aug && !running;
    assign ld_add_en = ld_add && !running;
    assign go        = start && !running && !ld_aug && !ld_add;
    assign shift_en  = running;
    assign done      = (st_q.phase == PH_DONE);

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE, PH_DONE: begin
                st_d.phase = PH_IDLE;
                if (go) begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                end
            end
            PH_RUN: begin
                if (st_q.cnt == LAST) begin
                    st_d.phase = PH_DONE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a run proceeds one count per cycle whatever the request inputs do
    assert_run_advances_R8: assert property (@(posedge clk) disable iff (rst)
        (running && st_q.cnt != LAST) |=> (running && st_q.cnt == $past(st_q.cnt) + 1'b1));

    // the last run cycle is followed by the done cycle
    assert_run_ends_done_R3: assert property (@(posedge clk) disable iff (rst)
        (running && st_q.cnt == LAST) |=> done);

    // a start colliding with a load never launches a run
    assert_start_load_clash_R10: assert property (@(posedge clk) disable iff (rst)
        (!running && (ld_aug || ld_add)) |=> !running);

endmodule

// File: rtl/sacc_shreg.sv
module sacc_shreg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    input  logic             fill,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } sreg_t;

    sreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.data = load_val;
        end else if (shift) begin
            st_d.data = {fill, st_q.data[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.data;

    // without load or shift the contents hold
    assert_reg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(q));

    // the filled bit appears at the top after a shift
    assert_top_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (q[WIDTH-1] == $past(fill)));

endmodule

// File: rtl/sacc_bitadd.sv
module sacc_bitadd (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit,
    output logic carry
);
    import sacc_pkg::*;

    typedef struct packed {
        logic c;
    } cy_t;

    cy_t        st_d, st_q;
    logic [1:0] fa;

    assign fa      = full_add(a_bit, b_bit, st_q.c);
    assign sum_bit = fa[0];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.c = 1'b0;
        end else if (en) begin
            st_d.c = fa[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.c <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry = st_q.c;

    assert_carry_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> !carry);

    assert_carry_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(carry));

endmodule

// File: rtl/serial_accum_adder.sv
module serial_accum_adder #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_aug,
    input  logic [WIDTH-1:0] aug_in,
    input  logic             ld_add,
    input  logic [WIDTH-1:0] add_in,
    input  logic             start,
    output logic             done,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    logic             shift_en;
    logic             ld_aug_en;
    logic             ld_add_en;
    logic             sbit;
    logic [WIDTH-1:0] aug_q;
    logic [WIDTH-1:0] add_q;

    sacc_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ld_aug    (ld_aug),
        .ld_add    (ld_add),
        .start     (start),
        .shift_en  (shift_en),
        .ld_aug_en (ld_aug_en),
        .ld_add_en (ld_add_en),
        .done      (done)
    );

    // augend register: takes the sum bit at its top during a run
    sacc_shreg #(.WIDTH(WIDTH)) u_aug (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_aug_en),
        .load_val (aug_in),
        .shift    (shift_en),
        .fill     (sbit),
        .q        (aug_q)
    );

    // addend register: drains to zero during a run
    sacc_shreg #(.WIDTH(WIDTH)) u_add (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_add_en),
        .load_val (add_in),
        .shift    (shift_en),
        .fill     (1'b0),
        .q        (add_q)
    );

    sacc_bitadd u_fa (
        .clk     (clk),
        .rst     (rst),
        .clr     (ld_aug_en),
        .en      (shift_en),
        .a_bit   (aug_q[0]),
        .b_bit   (add_q[0]),
        .sum_bit (sbit),
        .carry   (carry_out)
    );

    assign sum = aug_q;

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_addend_drained_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (add_q == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !ld_aug && !ld_add && !start) |=> ($stable(sum) && $stable(carry_out)));

endmodule

// File: tb/serial_accum_adder_tb.sv
module serial_accum_adder_tb;
    localparam int W = 4;
    localparam int M = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         ld_aug;
    logic [W-1:0] aug_in;
    logic         ld_add;
    logic [W-1:0] add_in;
    logic         start;
    logic         done;
    logic [W-1:0] sum;
    logic         carry_out;

    int checks = 0;
    int errors = 0;

    int ref_a;
    int ref_b;
    int ref_c;

    always #4 clk = ~clk;

    serial_accum_adder #(.WIDTH(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .ld_aug    (ld_aug),
        .aug_in    (aug_in),
        .ld_add    (ld_add),
        .add_in    (add_in),
        .start     (start),
        .done      (done),
        .sum       (sum),
        .carry_out (carry_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input bit la, input int a, input bit lb, input int b);
        @(negedge clk);
        ld_aug = la; aug_in = W'(a);
        ld_add = lb; add_in = W'(b);
        @(posedge clk);
        @(negedge clk);
        ld_aug = 1'b0; ld_add = 1'b0;
        if (la) begin ref_a = a & M; ref_c = 0; end
        if (lb) ref_b = b & M;
        chk(sum == W'(ref_a), "R2 sum after load", int'(sum), ref_a);
        chk(carry_out == ref_c[0], "R2 carry after load", int'(carry_out), ref_c);
    endtask

    // runs one addition; optionally fires requests during the run
    task automatic run_add(input bit inject, input string req);
        int total;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            ld_aug = 1'b1; aug_in = W'(~ref_a);
            ld_add = 1'b1; add_in = W'(~ref_b);
            start  = 1'b1;
        end
        for (int i = 0; i < W; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 1) begin
                ld_aug = 1'b0; ld_add = 1'b0; start = 1'b0;
            end
            if (i < W - 1) chk(done == 1'b0, "R3 done early", int'(done), 0);
        end
        total = ref_a + ref_b + ref_c;
        ref_a = total & M;
        ref_c = (total >> W) & 1;
        ref_b = 0;
        chk(done == 1'b1, "R3 done on time", int'(done), 1);
        chk(sum == W'(ref_a), req, int'(sum), ref_a);
        chk(carry_out == ref_c[0], req, int'(carry_out), ref_c);
        @(negedge clk);
        chk(done == 1'b0, "R3 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset;
        rst = 1'b1; ld_aug = 0; ld_add = 0; start = 0; aug_in = '0; add_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_a = 0; ref_b = 0; ref_c = 0;
        chk(sum == '0, "R1 sum", int'(sum), 0);
        chk(carry_out == 1'b0, "R1 carry", int'(carry_out), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
    endtask

    task automatic t_example;
        load(1, 4'b1011, 1, 4'b1001);
        run_add(0, "R5 example");
        chk(sum == 4'b0100 && carry_out == 1'b1, "R5 literal", int'({carry_out, sum}), 20);
    endtask

    task automatic t_chains;
        for (int n = 0; n < 8; n++) begin
            int len;
            len = 2 + (n % 4);
            load(1, int'($urandom_range(M, 0)), 1, int'($urandom_range(M, 0)));
            run_add(0, "R4 first add");
            for (int k = 1; k < len; k++) begin
                load(0, 0, 1, int'($urandom_range(M, 0)));
                run_add(0, "R6 accumulate");
            end
        end
    endtask

    task automatic t_drained;
        load(1, 13, 1, 7);
        run_add(0, "R4 pre drain");
        run_add(0, "R7 addend zero");
    endtask

    task automatic t_busy;
        load(1, 9, 1, 12);
        run_add(1, "R8 requests during run");
    endtask

    task automatic t_clash;
        @(negedge clk);
        ld_aug = 1'b1; aug_in = 4'd6; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ld_aug = 1'b0; start = 1'b0;
        ref_a = 6; ref_c = 0;
        chk(sum == 4'd6, "R10 load applied", int'(sum), 6);
        for (int i = 0; i < W + 2; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R10 start ignored", int'(done), 0);
        end
        chk(sum == 4'd6, "R10 sum unchanged", int'(sum), 6);
    endtask

    task automatic t_hold;
        load(1, 15, 1, 15);
        run_add(0, "R4 overflow");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(sum == W'(ref_a) && carry_out == ref_c[0] && !done, "R9 hold",
                int'({done, carry_out, sum}), int'({1'b0, ref_c[0], W'(ref_a)}));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset;
        t_example;
        t_chains;
        t_drained;
        t_busy;
        t_clash;
        t_hold;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule